// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing front end of a byte-wide serial memory. A fast system clock samples the two bus wires through synchronizers. The block finds start and stop conditions on the synchronized samples. It shifts bytes in and out and matches the device-address byte against three strap inputs. It acknowledges by enabling an open-drain pull-down on the data wire.

It carries out the whole transaction flow: byte and page writes, current-address reads, and random and sequential reads that begin with a dummy write. The flow is shared by two address prefixes, one for the main array and one for a read-only identification region. The storage, the address pointer and the write-cycle timer sit in neighbouring blocks. They see this engine as region selects, a word-address load strobe, a write-data strobe and a read-request strobe. The read source must present the requested byte on `rdData` in the cycle after `rdReq`.

Top module: `i2cm_slave_engine`

## Requirements
- R1: After reset the data pull-down is released and both region selects are low. A stop condition (data rising while the clock is high) drops both selects and returns the engine to idle. A start condition (data falling while the clock is high) moves it to device-address reception from any state.
- R2: A device-address byte is accepted when bits 3..1 equal `straps`. Bits 7..4 must be 1010, which selects the main array, or 1011, which selects the identification region. Bit 0 set to 1 means read and 0 means write. The matching region select stays high for the rest of the transaction.
- R3: On an address mismatch the engine gives no acknowledge. It ignores every later byte until the next start condition.
- R4: Every accepted byte is acknowledged by pulling the data line low for the ninth clock pulse. The pull-down only switches on while the synchronized clock is low.
- R5: In a write, the two bytes after the device address form the word address, high byte first. After the second byte, `addrLoad` pulses for one cycle with `wordAddr` = {high, low}.
- R6: Each data byte of an array write produces one `wrStrobe` pulse with the byte on `wrData`. Several bytes in one transaction are strobed in the order they arrive.
- R7: After a read device address is accepted, `rdReq` pulses once. The byte on `rdData` one cycle later is shifted out most significant bit first. This works both straight after a dummy write with a repeated start and as a current-address read.
- R8: While the master acknowledges a read byte, the engine requests and sends the next byte. A master no-acknowledge ends the read with no further `rdReq`.
- R9: Writes to the identification region are acknowledged and load the word address, but never pulse `wrStrobe`. Reads from it raise `selId` instead of `selArray`.
- R10: Nine clock pulses with the data line released, then a start, then a stop, leave the engine idle with the line released, even when it was in the middle of sending a byte.
- R11: A repeated start in the middle of a byte clears the bit count. The next eight bits are taken as a fresh device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock wire, asynchronous |
| sdaIn | input | 1 | Bus data wire as seen on the pad, asynchronous |
| sdaOeN | output | 1 | Active-low pull-down enable for the data wire |
| straps | input | 3 | Hard-wired device address bits |
| selArray | output | 1 | Transaction targets the main array |
| selId | output | 1 | Transaction targets the identification region |
| wordAddr | output | 16 | Received word address {high byte, low byte} |
| addrLoad | output | 1 | One-cycle strobe: `wordAddr` is new |
| wrData | output | 8 | Received write data byte |
| wrStrobe | output | 1 | One-cycle strobe: write `wrData` to the array |
| rdReq | output | 1 | One-cycle strobe: supply the next read byte |
| rdData | input | 8 | Read byte, valid the cycle after `rdReq` |

## Verification
The properties assume that each bus clock phase lasts several system clocks. Under that assumption a synchronized falling edge can never be followed by a rising edge one cycle later, and a pull-down switched on after a fall is always seen while the clock is low. They also assume that the read source and the bus wires change only between sampling edges. The bench drives the bus on the falling system-clock edge with quarter-bit phases of five system clocks, and its memory model returns `rdData` one cycle after `rdReq`. The master releases the data line during every slave-driven slot, so the wired-AND line model never sees two drivers fighting.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int WADDR_W = 2 * BYTE_W;
  localparam logic [3:0] PFX_ARRAY = 4'b1010;
  localparam logic [3:0] PFX_ID    = 4'b1011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RACK, ST_RDAT, ST_SKIP
  } state_t;

  // events from the datapath to the control
  typedef struct packed {
    logic              startEv;
    logic              stopEv;
    logic              byteDone;
    logic              ackDone;
    logic              sdaBit;
    logic [BYTE_W-1:0] rxByte;
  } busEv_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic ackPend;
    logic txMode;
    logic latchHi;
    logic latchLo;
    logic latchData;
    logic loadTx;
  } ctlStb_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclQ, sdaQ;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclChain[SYNC_STAGES-1];
  assign sdaS = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclQ;
  assign sclFall = ~sclS & sclQ;
  assign startEv = sclS & sclQ & sdaQ & ~sdaS;
  assign stopEv  = sclS & sclQ & ~sdaQ & sdaS;
endmodule

// File: rtl/i2cm_dpath.sv
module i2cm_dpath
  import i2cm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclRise,
  input  logic                sclFall,
  input  logic                startEv,
  input  logic                stopEv,
  input  logic                sdaS,
  input  ctlStb_t             ctl,
  input  logic [BYTE_W-1:0]   rdData,
  output busEv_t              ev,
  output logic                sdaOeN,
  output logic [WADDR_W-1:0]  wordAddr,
  output logic [BYTE_W-1:0]   wrData
);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxReg, txReg, addrHi, addrLo;
  logic [2:0]        txIdx;
  logic              drvLow;

  assign ev.startEv  = startEv;
  assign ev.stopEv   = stopEv;
  assign ev.byteDone = sclRise && (bitCnt == LAST_BIT);
  assign ev.ackDone  = sclRise && (bitCnt == ACK_SLOT);
  assign ev.sdaBit   = sdaS;
  assign ev.rxByte   = {rxReg[BYTE_W-2:0], sdaS};

  assign txIdx = 3'd7 - bitCnt[2:0];

  // bit counter counts clock rises within a 9-pulse byte frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxReg  <= '0;
    end else if (startEv || stopEv) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      if (bitCnt == ACK_SLOT) begin
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
        rxReg  <= {rxReg[BYTE_W-2:0], sdaS};
      end
    end
  end

  // pull-down changes only right after a falling clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvLow <= 1'b0;
    end else if (startEv || stopEv) begin
      drvLow <= 1'b0;
    end else if (sclFall) begin
      if (bitCnt == ACK_SLOT) drvLow <= ctl.ackPend;
      else                    drvLow <= ctl.txMode & ~txReg[txIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '1;
      addrHi <= '0;
      addrLo <= '0;
      wrData <= '0;
    end else begin
      if (ctl.loadTx)    txReg  <= rdData;
      if (ctl.latchHi)   addrHi <= ev.rxByte;
      if (ctl.latchLo)   addrLo <= ev.rxByte;
      if (ctl.latchData) wrData <= ev.rxByte;
    end
  end

  assign sdaOeN   = ~drvLow;
  assign wordAddr = {addrHi, addrLo};
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEv_t     ev,
  input  logic [2:0] straps,
  output ctlStb_t    ctl,
  output logic       selArray,
  output logic       selId,
  output logic       addrLoad,
  output logic       wrStrobe,
  output logic       rdReq
);
  state_t state;
  logic   regionId, ackPend, loadTxQ, devMatch, active;

  assign devMatch = (ev.rxByte[3:1] == straps) &&
                    ((ev.rxByte[7:4] == PFX_ARRAY) || (ev.rxByte[7:4] == PFX_ID));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      regionId <= 1'b0;
      ackPend  <= 1'b0;
      addrLoad <= 1'b0;
      wrStrobe <= 1'b0;
      rdReq    <= 1'b0;
      loadTxQ  <= 1'b0;
    end else begin
      addrLoad <= 1'b0;
      wrStrobe <= 1'b0;
      rdReq    <= 1'b0;
      loadTxQ  <= rdReq;
      if (ev.startEv) begin
        state   <= ST_DEV;
        ackPend <= 1'b0;
      end else if (ev.stopEv) begin
        state   <= ST_IDLE;
        ackPend <= 1'b0;
      end else if (ev.byteDone) begin
        ackPend <= 1'b0;
        unique case (state)
          ST_DEV: begin
            if (devMatch) begin
              regionId <= ev.rxByte[4];
              ackPend  <= 1'b1;
              if (ev.rxByte[0]) begin
                state <= ST_RACK;
                rdReq <= 1'b1;
              end else begin
                state <= ST_AHI;
              end
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_AHI: begin
            ackPend <= 1'b1;
            state   <= ST_ALO;
          end
          ST_ALO: begin
            ackPend  <= 1'b1;
            addrLoad <= 1'b1;
            state    <= ST_WDAT;
          end
          ST_WDAT: begin
            ackPend  <= 1'b1;
            wrStrobe <= ~regionId;
          end
          default: ackPend <= 1'b0;
        endcase
      end else if (ev.ackDone) begin
        if (state == ST_RACK) begin
          state <= ST_RDAT;
        end else if (state == ST_RDAT) begin
          if (!ev.sdaBit) rdReq <= 1'b1;
          else            state <= ST_SKIP;
        end
      end
    end
  end

  assign active = (state == ST_AHI) || (state == ST_ALO) || (state == ST_WDAT) ||
                  (state == ST_RACK) || (state == ST_RDAT);
  assign selArray = active & ~regionId;
  assign selId    = active & regionId;

  always_comb begin
    ctl           = '0;
    ctl.ackPend   = ackPend;
    ctl.txMode    = (state == ST_RDAT);
    ctl.latchHi   = ev.byteDone && (state == ST_AHI);
    ctl.latchLo   = ev.byteDone && (state == ST_ALO);
    ctl.latchData = ev.byteDone && (state == ST_WDAT) && !regionId;
    ctl.loadTx    = loadTxQ;
  end
endmodule

// File: rtl/i2cm_slave_engine.sv
module i2cm_slave_engine
  import i2cm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOeN,
  input  logic [2:0]         straps,
  output logic               selArray,
  output logic               selId,
  output logic [WADDR_W-1:0] wordAddr,
  output logic               addrLoad,
  output logic [BYTE_W-1:0]  wrData,
  output logic               wrStrobe,
  output logic               rdReq,
  input  logic [BYTE_W-1:0]  rdData
);
  logic    sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  busEv_t  ev;
  ctlStb_t ctl;

  i2cm_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2cm_dpath u_dpath (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaS(sdaS), .ctl(ctl),
    .rdData(rdData), .ev(ev), .sdaOeN(sdaOeN), .wordAddr(wordAddr),
    .wrData(wrData)
  );

  i2cm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .straps(straps), .ctl(ctl),
    .selArray(selArray), .selId(selId), .addrLoad(addrLoad),
    .wrStrobe(wrStrobe), .rdReq(rdReq)
  );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk,
  input logic rstN,
  input logic sclS,
  input logic startEv,
  input logic stopEv,
  input logic sdaOeN,
  input logic selArray,
  input logic selId,
  input logic addrLoad,
  input logic wrStrobe,
  input logic rdReq
);
  // R4
  pull_low_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOeN) |-> !sclS);

  // R4
  pull_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdaOeN |-> (selArray || selId));

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (!selArray && !selId));

  // R1
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (!selArray && !selId));

  // R9
  id_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> selArray);

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R7
  rd_in_txn_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (selArray || selId));

  // R5
  load_in_txn_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |-> (selArray || selId));
endmodule

bind i2cm_slave_engine i2cm_chk u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startEv(startEv), .stopEv(stopEv),
  .sdaOeN(sdaOeN), .selArray(selArray), .selId(selId), .addrLoad(addrLoad),
  .wrStrobe(wrStrobe), .rdReq(rdReq)
);

// File: tb/i2cm_slave_engine_tb.sv
module i2cm_slave_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_AW = 8'hAA, DEV_AR = 8'hAB;
  localparam logic [7:0] DEV_IW = 8'hBA, DEV_IR = 8'hBB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOeN, selArray, selId, addrLoad, wrStrobe, rdReq;
  logic [15:0] wordAddr;
  logic [7:0]  wrData, rdData;
  logic sdaLine;

  int nChecks = 0, nFail = 0;
  int wrCnt = 0, rdCnt = 0, loadCnt = 0;
  logic [7:0]  wrLog [0:31];
  logic [15:0] ptr = '0, lastAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & sdaOeN;

  i2cm_slave_engine u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOeN(sdaOeN),
    .straps(STRAP), .selArray(selArray), .selId(selId), .wordAddr(wordAddr),
    .addrLoad(addrLoad), .wrData(wrData), .wrStrobe(wrStrobe), .rdReq(rdReq),
    .rdData(rdData)
  );

  function automatic logic [7:0] expByte(input logic isId, input logic [15:0] p);
    return isId ? (8'hC0 | {4'h0, p[3:0]}) : (p[7:0] ^ {3'b000, p[12:8]});
  endfunction

  // memory and pointer model of the neighbouring blocks
  always @(posedge clk) begin
    rdData <= 8'h00;
    if (addrLoad) begin
      ptr <= wordAddr; lastAddr <= wordAddr; loadCnt <= loadCnt + 1;
    end
    if (wrStrobe) begin
      wrLog[wrCnt[4:0]] <= wrData; wrCnt <= wrCnt + 1; ptr <= ptr + 16'd1;
    end
    if (rdReq) begin
      rdData <= expByte(selId, ptr); rdCnt <= rdCnt + 1; ptr <= ptr + 16'd1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); seen = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, ack);
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s); b[i] = s;
    end
    clockBit(~masterAck, s);
    sdaM = 1'b1;
  endtask

  task automatic writeHeader(input logic [7:0] dev, input logic [15:0] a, input string tag);
    logic ack;
    busStart();
    sendByte(dev, ack);      check({tag, " dev ack"}, ack, 1'b0);
    sendByte(a[15:8], ack);  check({tag, " hi ack"}, ack, 1'b0);
    sendByte(a[7:0], ack);   check({tag, " lo ack"}, ack, 1'b0);
  endtask

  task automatic testReset();
    check("R1 reset oe", sdaOeN, 1'b1);
    check("R1 reset sel", {selArray, selId}, 2'b00);
  endtask

  task automatic testByteWrite();
    logic ack; int w0 = wrCnt, l0 = loadCnt;
    writeHeader(DEV_AW, 16'h1234, "R2");
    check("R5 addr loaded", loadCnt - l0, 1);
    check("R5 word addr", lastAddr, 16'h1234);
    sendByte(8'h5C, ack);
    check("R4 data ack", ack, 1'b0);
    check("R2 array sel", {selArray, selId}, 2'b10);
    busStop();
    check("R6 one strobe", wrCnt - w0, 1);
    check("R6 data", wrLog[w0[4:0]], 8'h5C);
    check("R1 stop idle", {selArray, selId}, 2'b00);
  endtask

  task automatic testPageWrite();
    logic ack; int w0 = wrCnt;
    logic [7:0] d [3] = '{8'h11, 8'h22, 8'h33};
    writeHeader(DEV_AW, 16'h0040, "R6");
    for (int i = 0; i < 3; i++) begin
      sendByte(d[i], ack); check("R6 page ack", ack, 1'b0);
    end
    busStop();
    check("R6 page count", wrCnt - w0, 3);
    for (int i = 0; i < 3; i++) check("R6 page order", wrLog[(w0 + i) % 32], d[i]);
  endtask

  task automatic testMismatch();
    logic ack; int w0 = wrCnt, l0 = loadCnt;
    busStart();
    sendByte(8'hA0, ack);  check("R3 no ack", ack, 1'b1);
    sendByte(8'h00, ack);  check("R3 ignored byte", ack, 1'b1);
    sendByte(8'h00, ack);
    check("R3 no load", loadCnt - l0, 0);
    check("R3 no sel", {selArray, selId}, 2'b00);
    busStop();
    check("R3 no write", wrCnt - w0, 0);
  endtask

  task automatic testRandomRead();
    logic ack; logic [7:0] b; int r0;
    writeHeader(DEV_AW, 16'h0123, "R7");
    busStart();
    r0 = rdCnt;
    sendByte(DEV_AR, ack); check("R7 read ack", ack, 1'b0);
    recvByte(1'b1, b); check("R7 first byte", b, 8'h22);
    recvByte(1'b1, b); check("R8 second byte", b, 8'h25);
    recvByte(1'b0, b); check("R8 third byte", b, 8'h24);
    repeat (4) @(negedge clk);
    check("R8 nack stops requests", rdCnt - r0, 3);
    busStop();
  endtask

  task automatic testCurrentRead();
    logic ack; logic [7:0] b;
    busStart();
    sendByte(DEV_AR, ack); check("R7 current ack", ack, 1'b0);
    recvByte(1'b0, b); check("R7 current byte", b, 8'h27);
    busStop();
  endtask

  task automatic testIdRead();
    logic ack; logic [7:0] b;
    writeHeader(DEV_IW, 16'h0800, "R9");
    busStart();
    sendByte(DEV_IR, ack); check("R9 id read ack", ack, 1'b0);
    check("R9 id sel", {selArray, selId}, 2'b01);
    recvByte(1'b1, b); check("R9 id byte0", b, 8'hC0);
    recvByte(1'b0, b); check("R9 id byte1", b, 8'hC1);
    busStop();
  endtask

  task automatic testIdWrite();
    logic ack; int w0 = wrCnt;
    writeHeader(DEV_IW, 16'h0800, "R9");
    sendByte(8'h77, ack); check("R9 id data ack", ack, 1'b0);
    busStop();
    check("R9 id no write", wrCnt - w0, 0);
  endtask

  task automatic testRestartMidByte();
    logic ack, s; logic [7:0] b, e;
    busStart();
    clockBit(1'b1, s); clockBit(1'b0, s); clockBit(1'b1, s);
    busStart();
    e = expByte(1'b0, ptr);
    sendByte(DEV_AR, ack); check("R11 restart ack", ack, 1'b0);
    recvByte(1'b0, b); check("R11 restart byte", b, e);
    busStop();
  endtask

  task automatic testBusClear();
    logic ack, s; int w0;
    busStart();
    sendByte(DEV_AR, ack); check("R10 setup ack", ack, 1'b0);
    for (int i = 0; i < 3; i++) clockBit(1'b1, s);
    for (int i = 0; i < 9; i++) clockBit(1'b1, s);
    busStart();
    busStop();
    check("R10 cleared sel", {selArray, selId}, 2'b00);
    check("R10 released", sdaOeN, 1'b1);
    w0 = wrCnt;
    writeHeader(DEV_AW, 16'h0200, "R10");
    sendByte(8'h9E, ack);
    busStop();
    check("R10 usable after clear", wrCnt - w0, 1);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testByteWrite();
    testPageWrite();
    testMismatch();
    testRandomRead();
    testCurrentRead();
    testIdRead();
    testIdWrite();
    testRestartMidByte();
    testBusClear();
    finishRun();
  end
endmodule